// File: doc/BRIEF.md
# Interrupt Source Destination Router

This block is the routing stage for one interrupt source in a multiprocessor interrupt controller. It keeps the source's destination register, which can name target CPUs in two ways. A low field names CPUs for ordinary delivery. A second field, stored in reverse CPU order near the top of the word, names CPUs for critical delivery. The block decodes the stored word into an output kind (normal or critical) and a bitmap of target CPUs.

A small configuration port sets the source priority and the delivery mode. When a pending strobe arrives, the block delivers the interrupt on the next clock edge. In directed mode it goes to every selected CPU. In distributed mode it goes to a single CPU, chosen round-robin.

Critical deliveries drive a per-CPU critical line directly and raise the source's activity flag. Normal deliveries assert a CPU's interrupt line only when the source priority is strictly above that CPU's task priority. Every output is a level that holds until its per-CPU clear input is pulsed.

Top module: `irq_dest_router`

## Requirements
- R1: A destination write keeps only these bits: bits 3..0 (normal field), bits 30..27 (critical field) and bit 31 (external-pin bit). All other bits are stored as zero, and the stored word reads back on `dest_reg` one cycle after the write.
- R2: If any critical bit is set, the output kind is critical. Stored bit 30-i then selects CPU i, and the normal bits are ignored even when they are also set.
- R3: If no critical bit is set, the output kind is normal and stored bit i selects CPU i.
- R4: A critical delivery sets `irq_crit[i]` for each target CPU one cycle after the strobe, whatever the task priorities are. It also sets `src_active`.
- R5: A normal delivery to CPU i sets `irq_norm[i]` only when the source priority is greater than task priority i. The task priority of CPU i is `task_prio[4*i+3:4*i]`. When the two are equal, or the source priority is lower, the CPU receives nothing.
- R6: With `cfg_distrib` = 0 (directed mode), one strobe delivers to every CPU in the destination bitmap.
- R7: With `cfg_distrib` = 1 (distributed mode), the search starts at the CPU after `last_cpu` and wraps from CPU 3 to CPU 0. Only the first selected CPU receives the interrupt, and `last_cpu` becomes that CPU. An empty bitmap delivers nothing and leaves `last_cpu` unchanged.
- R8: Reset leaves these values: all outputs low, a zero destination register, `src_active` = 0 and `last_cpu` = 3. With that pointer, the first distributed delivery goes to CPU 0 when CPU 0 is selected.
- R9: Outputs are levels. `clr_norm[i]` clears only `irq_norm[i]`, and `clr_crit[i]` clears only `irq_crit[i]`. Other outputs hold.
- R10: A configuration write clears `src_active`.
- R11: No output rises in a cycle that does not follow a pending strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dest_wr_en | input | 1 | Destination register write strobe |
| dest_wr_data | input | 32 | Destination register write data |
| cfg_wr_en | input | 1 | Priority/mode write strobe |
| cfg_prio | input | 4 | Source priority to store |
| cfg_distrib | input | 1 | Delivery mode to store: 0 directed, 1 distributed |
| task_prio | input | 16 | Per-CPU task priorities, 4 bits per CPU |
| pend_strobe | input | 1 | Source pending pulse |
| clr_norm | input | 4 | Per-CPU clear of the normal output |
| clr_crit | input | 4 | Per-CPU clear of the critical output |
| irq_norm | output | 4 | Per-CPU normal interrupt level |
| irq_crit | output | 4 | Per-CPU critical interrupt level |
| dest_reg | output | 32 | Stored destination register |
| src_active | output | 1 | Source activity flag |
| last_cpu | output | 2 | Last CPU served in distributed mode |

## Verification
The bench writes a word with both normal and critical bits set. A design that let the normal field win would raise `irq_norm` where `irq_crit` was due. It also pairs a critical target with a task priority above the source priority. A router that wrongly applied the comparison would deliver nothing.

Equal source and task priorities must suppress delivery. An off-by-one comparison would raise the line in that case.

In distributed mode the bench checks several points. The first pick comes straight after reset. The search must wrap from CPU 3 back to CPU 0. An empty bitmap must leave the pointer where it was. A selector that restarted at CPU 0, or that moved the pointer with no target, shows a wrong `last_cpu` or the wrong CPU line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic {
      OUT_NORMAL = 1'b0,
      OUT_CRIT   = 1'b1
   } out_kind_e;

endpackage

// File: rtl/dest_decode.sv
module dest_decode #(
   parameter int N        = 4,
   parameter int REG_W    = 32,
   parameter int CRIT_TOP = 30,
   parameter int EXT_BIT  = 31,
   parameter bit CRIT_EN  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [REG_W-1:0]             wr_data,
   output logic [REG_W-1:0]             reg_q,
   output irq_route_pkg::out_kind_e     kind,
   output logic [N-1:0]                 dest_map
);
   import irq_route_pkg::*;

   localparam int CRIT_LOW = CRIT_TOP - N + 1;

   function automatic logic [REG_W-1:0] keep_bits();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < N; i++) begin
         m[i] = 1'b1;
         if (CRIT_EN) m[CRIT_TOP-i] = 1'b1;
      end
      if (CRIT_EN) m[EXT_BIT] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] KEEP = keep_bits();

   generate
      if (N < 1) begin : g_bad_n
         $error("dest_decode: N must be at least 1");
      end
      if (CRIT_EN && (CRIT_LOW <= N - 1)) begin : g_bad_overlap
         $error("dest_decode: critical field overlaps normal field");
      end
      if (CRIT_EN && (EXT_BIT <= CRIT_TOP || EXT_BIT >= REG_W)) begin : g_bad_ext
         $error("dest_decode: external bit position invalid");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_q <= '0;
      else if (wr_en)  reg_q <= wr_data & KEEP;
   end

   logic [N-1:0] norm_map;
   logic [N-1:0] crit_map;

   assign norm_map = reg_q[N-1:0];

   generate
      if (CRIT_EN) begin : g_crit
         for (genvar i = 0; i < N; i++) begin : g_rev
            assign crit_map[i] = reg_q[CRIT_TOP-i];
         end
      end else begin : g_nocrit
         assign crit_map = '0;
      end
   endgenerate

   always_comb begin
      if (|crit_map) begin
         kind     = OUT_CRIT;
         dest_map = crit_map;
      end else begin
         kind     = OUT_NORMAL;
         dest_map = norm_map;
      end
   end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     cand,
   input  logic [IDX_W-1:0] last,
   output logic             found,
   output logic [IDX_W-1:0] pick
);

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 1; k <= N; k++) begin
         int c;
         c = (int'(last) + k) % N;
         if (!found && cand[c]) begin
            found = 1'b1;
            pick  = IDX_W'(c);
         end
      end
   end

endmodule

// File: rtl/cpu_deliver.sv
module cpu_deliver #(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_norm,
   input  logic              fire_crit,
   input  logic [PRIO_W-1:0] src_prio,
   input  logic [PRIO_W-1:0] task_prio,
   input  logic              clr_norm,
   input  logic              clr_crit,
   output logic              irq_norm,
   output logic              irq_crit
);

   logic prio_ok;
   assign prio_ok = src_prio > task_prio;

   always_ff @(posedge clk) begin
      if (!rst_n)                    irq_norm <= 1'b0;
      else if (fire_norm && prio_ok) irq_norm <= 1'b1;
      else if (clr_norm)             irq_norm <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_crit <= 1'b0;
      else if (fire_crit) irq_crit <= 1'b1;
      else if (clr_crit)  irq_crit <= 1'b0;
   end

endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router #(
   parameter int N        = 4,
   parameter int PRIO_W   = 4,
   parameter int REG_W    = 32,
   parameter int CRIT_TOP = 30,
   parameter int EXT_BIT  = 31,
   parameter bit CRIT_EN  = 1'b1,
   localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dest_wr_en,
   input  logic [REG_W-1:0]      dest_wr_data,
   input  logic                  cfg_wr_en,
   input  logic [PRIO_W-1:0]     cfg_prio,
   input  logic                  cfg_distrib,
   input  logic [N*PRIO_W-1:0]   task_prio,
   input  logic                  pend_strobe,
   input  logic [N-1:0]          clr_norm,
   input  logic [N-1:0]          clr_crit,
   output logic [N-1:0]          irq_norm,
   output logic [N-1:0]          irq_crit,
   output logic [REG_W-1:0]      dest_reg,
   output logic                  src_active,
   output logic [IDX_W-1:0]      last_cpu
);
   import irq_route_pkg::*;

   generate
      if (PRIO_W < 1) begin : g_bad_prio
         $error("irq_dest_router: PRIO_W must be at least 1");
      end
   endgenerate

   out_kind_e        kind;
   logic [N-1:0]     dest_map;
   logic [PRIO_W-1:0] prio_q;
   logic             distrib_q;
   logic             rr_found;
   logic [IDX_W-1:0] rr_idx;
   logic [N-1:0]     tgt;
   logic [N-1:0]     fire_n;
   logic [N-1:0]     fire_c;

   dest_decode #(
      .N(N), .REG_W(REG_W), .CRIT_TOP(CRIT_TOP),
      .EXT_BIT(EXT_BIT), .CRIT_EN(CRIT_EN)
   ) dec_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(dest_wr_en), .wr_data(dest_wr_data),
      .reg_q(dest_reg), .kind(kind), .dest_map(dest_map)
   );

   rr_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
      .cand(dest_map), .last(last_cpu),
      .found(rr_found), .pick(rr_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q    <= '0;
         distrib_q <= 1'b0;
      end else if (cfg_wr_en) begin
         prio_q    <= cfg_prio;
         distrib_q <= cfg_distrib;
      end
   end

   always_comb begin
      if (distrib_q) tgt = rr_found ? (N'(1) << rr_idx) : '0;
      else           tgt = dest_map;
      fire_n = '0;
      fire_c = '0;
      if (pend_strobe) begin
         if (kind == OUT_CRIT) fire_c = tgt;
         else                  fire_n = tgt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                    last_cpu <= IDX_W'(N - 1);
      else if (pend_strobe && distrib_q && rr_found) last_cpu <= rr_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         src_active <= 1'b0;
      else if (|fire_c)   src_active <= 1'b1;
      else if (cfg_wr_en) src_active <= 1'b0;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_cpu
         cpu_deliver #(.PRIO_W(PRIO_W)) dlv_i (
            .clk(clk), .rst_n(rst_n),
            .fire_norm(fire_n[i]), .fire_crit(fire_c[i]),
            .src_prio(prio_q),
            .task_prio(task_prio[i*PRIO_W +: PRIO_W]),
            .clr_norm(clr_norm[i]), .clr_crit(clr_crit[i]),
            .irq_norm(irq_norm[i]), .irq_crit(irq_crit[i])
         );
      end
   endgenerate

endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
   parameter int N        = 4,
   parameter int REG_W    = 32,
   parameter int CRIT_TOP = 30,
   parameter int EXT_BIT  = 31,
   parameter bit CRIT_EN  = 1'b1,
   parameter int IDX_W    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pend_strobe,
   input logic             distrib_q,
   input logic [N-1:0]     clr_norm,
   input logic [N-1:0]     irq_norm,
   input logic [N-1:0]     irq_crit,
   input logic [REG_W-1:0] dest_reg,
   input logic             src_active,
   input logic [IDX_W-1:0] last_cpu
);

   logic [REG_W-1:0] legal;
   logic [N-1:0]     crit_sel;

   always_comb begin
      legal    = '0;
      crit_sel = '0;
      for (int i = 0; i < N; i++) begin
         legal[i] = 1'b1;
         if (CRIT_EN) begin
            legal[CRIT_TOP-i] = 1'b1;
            crit_sel[i] = dest_reg[CRIT_TOP-i];
         end
      end
      if (CRIT_EN) legal[EXT_BIT] = 1'b1;
   end

   assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_reg & ~legal) == '0);

   assert_crit_blocks_norm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_strobe && crit_sel != '0) |=> (irq_norm & ~$past(irq_norm)) == '0);

   assert_crit_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_strobe && !distrib_q && crit_sel != '0) |=> (($past(crit_sel) & ~irq_crit) == '0 && src_active));

   assert_single_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_strobe && distrib_q) |=>
         $countones((irq_norm & ~$past(irq_norm)) | (irq_crit & ~$past(irq_crit))) <= 1);

   assert_last_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(last_cpu) < N);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_strobe && clr_norm != '0) |=> (irq_norm & $past(clr_norm)) == '0);

   assert_no_spont_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_strobe |=> ((irq_norm & ~$past(irq_norm)) == '0 && (irq_crit & ~$past(irq_crit)) == '0));

   assert_active_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_active) |-> $past(pend_strobe));

endmodule

bind irq_dest_router irq_dest_router_chk #(
   .N(N), .REG_W(REG_W), .CRIT_TOP(CRIT_TOP),
   .EXT_BIT(EXT_BIT), .CRIT_EN(CRIT_EN), .IDX_W(IDX_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .pend_strobe(pend_strobe),
   .distrib_q(distrib_q), .clr_norm(clr_norm),
   .irq_norm(irq_norm), .irq_crit(irq_crit),
   .dest_reg(dest_reg), .src_active(src_active), .last_cpu(last_cpu)
);

// File: tb/irq_dest_router_tb_top.sv
module irq_dest_router_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dest_wr_en = 1'b0;
   logic [31:0] dest_wr_data = '0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_prio = '0;
   logic        cfg_distrib = 1'b0;
   logic [15:0] task_prio = 16'h7254;
   logic        pend_strobe = 1'b0;
   logic [3:0]  clr_norm = '0;
   logic [3:0]  clr_crit = '0;
   logic [3:0]  irq_norm;
   logic [3:0]  irq_crit;
   logic [31:0] dest_reg;
   logic        src_active;
   logic [1:0]  last_cpu;

   always #2.5 clk = ~clk;

   irq_dest_router dut_i (
      .clk(clk), .rst_n(rst_n),
      .dest_wr_en(dest_wr_en), .dest_wr_data(dest_wr_data),
      .cfg_wr_en(cfg_wr_en), .cfg_prio(cfg_prio), .cfg_distrib(cfg_distrib),
      .task_prio(task_prio), .pend_strobe(pend_strobe),
      .clr_norm(clr_norm), .clr_crit(clr_crit),
      .irq_norm(irq_norm), .irq_crit(irq_crit),
      .dest_reg(dest_reg), .src_active(src_active), .last_cpu(last_cpu)
   );

   typedef struct {
      logic [3:0]  n;
      logic [3:0]  c;
      logic [31:0] r;
      logic [1:0]  l;
      logic        a;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   // monitor: compares one expected item per cycle at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (irq_norm !== e.n || irq_crit !== e.c || dest_reg !== e.r ||
                last_cpu !== e.l || src_active !== e.a) begin
               n_fail++;
               $display("FAIL %s: actual norm=%b crit=%b reg=%h last=%0d act=%b expected norm=%b crit=%b reg=%h last=%0d act=%b",
                        e.tag, irq_norm, irq_crit, dest_reg, last_cpu, src_active,
                        e.n, e.c, e.r, e.l, e.a);
            end
         end
      end
   end

   // driver: inputs already set at a falling edge; one clock, then queue the expectation
   task automatic go(input string tag, input logic [3:0] en, input logic [3:0] ec,
                     input logic [31:0] er, input logic [1:0] el, input logic ea);
      exp_t e;
      @(posedge clk);
      e.n = en; e.c = ec; e.r = er; e.l = el; e.a = ea; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      dest_wr_en  = 1'b0;
      cfg_wr_en   = 1'b0;
      pend_strobe = 1'b0;
      clr_norm    = '0;
      clr_crit    = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      go("R8 reset state", 4'b0000, 4'b0000, 32'h0, 2'd3, 1'b0);

      dest_wr_en = 1'b1; dest_wr_data = 32'hFFFF_FFFF;
      go("R1 all-ones write masked", 4'b0000, 4'b0000, 32'hF800_000F, 2'd3, 1'b0);
      dest_wr_en = 1'b1; dest_wr_data = 32'h0000_00A5;
      go("R1 junk bits dropped", 4'b0000, 4'b0000, 32'h0000_0005, 2'd3, 1'b0);
      cfg_wr_en = 1'b1; cfg_prio = 4'd5; cfg_distrib = 1'b0;
      go("R11 config write no delivery", 4'b0000, 4'b0000, 32'h5, 2'd3, 1'b0);

      pend_strobe = 1'b1;
      go("R6 R5 R3 directed to CPU0 and CPU2", 4'b0101, 4'b0000, 32'h5, 2'd3, 1'b0);
      clr_norm = 4'hF;
      go("R9 clear all normal", 4'b0000, 4'b0000, 32'h5, 2'd3, 1'b0);

      dest_wr_en = 1'b1; dest_wr_data = 32'h2;
      go("R1 write CPU1", 4'b0000, 4'b0000, 32'h2, 2'd3, 1'b0);
      pend_strobe = 1'b1;
      go("R5 equal priority suppressed", 4'b0000, 4'b0000, 32'h2, 2'd3, 1'b0);

      cfg_wr_en = 1'b1; cfg_prio = 4'd8; cfg_distrib = 1'b0;
      dest_wr_en = 1'b1; dest_wr_data = 32'hF;
      go("R1 write all normal", 4'b0000, 4'b0000, 32'hF, 2'd3, 1'b0);
      pend_strobe = 1'b1;
      go("R6 directed to all four", 4'b1111, 4'b0000, 32'hF, 2'd3, 1'b0);
      clr_norm = 4'b0100;
      go("R9 clear CPU2 only", 4'b1011, 4'b0000, 32'hF, 2'd3, 1'b0);
      go("R9 levels hold", 4'b1011, 4'b0000, 32'hF, 2'd3, 1'b0);
      clr_crit = 4'hF;
      go("R9 critical clear leaves normal", 4'b1011, 4'b0000, 32'hF, 2'd3, 1'b0);
      clr_norm = 4'hF;
      go("R9 clear rest", 4'b0000, 4'b0000, 32'hF, 2'd3, 1'b0);

      cfg_wr_en = 1'b1; cfg_prio = 4'd1; cfg_distrib = 1'b0;
      dest_wr_en = 1'b1; dest_wr_data = 32'h2000_0001;
      go("R1 critical plus normal write", 4'b0000, 4'b0000, 32'h2000_0001, 2'd3, 1'b0);
      pend_strobe = 1'b1;
      go("R2 R4 critical wins, priority ignored", 4'b0000, 4'b0010, 32'h2000_0001, 2'd3, 1'b1);
      dest_wr_en = 1'b1; dest_wr_data = 32'h4800_0000;
      go("R1 reversed critical write", 4'b0000, 4'b0010, 32'h4800_0000, 2'd3, 1'b1);
      pend_strobe = 1'b1;
      go("R2 bit30 CPU0 bit27 CPU3", 4'b0000, 4'b1011, 32'h4800_0000, 2'd3, 1'b1);

      cfg_wr_en = 1'b1; cfg_prio = 4'd8; cfg_distrib = 1'b1;
      go("R10 config write clears activity", 4'b0000, 4'b1011, 32'h4800_0000, 2'd3, 1'b0);
      clr_crit = 4'hF;
      go("R9 clear critical", 4'b0000, 4'b0000, 32'h4800_0000, 2'd3, 1'b0);

      dest_wr_en = 1'b1; dest_wr_data = 32'h3;
      go("R1 write CPU0 CPU1", 4'b0000, 4'b0000, 32'h3, 2'd3, 1'b0);
      pend_strobe = 1'b1;
      go("R7 R8 first pick CPU0", 4'b0001, 4'b0000, 32'h3, 2'd0, 1'b0);
      pend_strobe = 1'b1;
      go("R7 next pick CPU1", 4'b0011, 4'b0000, 32'h3, 2'd1, 1'b0);
      pend_strobe = 1'b1;
      go("R7 wrap to CPU0", 4'b0011, 4'b0000, 32'h3, 2'd0, 1'b0);
      clr_norm = 4'hF;
      dest_wr_en = 1'b1; dest_wr_data = 32'h0;
      go("R9 clear and empty map", 4'b0000, 4'b0000, 32'h0, 2'd0, 1'b0);
      pend_strobe = 1'b1;
      go("R7 empty map no move", 4'b0000, 4'b0000, 32'h0, 2'd0, 1'b0);

      dest_wr_en = 1'b1; dest_wr_data = 32'h5000_0000;
      go("R1 critical CPU0 CPU2", 4'b0000, 4'b0000, 32'h5000_0000, 2'd0, 1'b0);
      pend_strobe = 1'b1;
      go("R7 R4 distributed critical to CPU2", 4'b0000, 4'b0100, 32'h5000_0000, 2'd2, 1'b1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule